// File: doc/BRIEF.md
# SDRAM Single-Burst Write Sequencer

This block turns one user write request into the command, address, bank and data pin activity that a synchronous DRAM needs for a four-word write burst, and closes the row with a separately timed, explicit precharge rather than an automatic one. A request carries a bank, a row, a column, four data words and a flag that chooses whether the closing precharge targets one bank or all of them. It is accepted with a valid/ready handshake.

Once a request is accepted, the sequencer opens the row, waits the row-to-column delay, and issues the write with the automatic-precharge address bit held low. Data words go out on four consecutive clocks, starting in the clock of the write command. The sequencer then waits the write-recovery time and the row active time, issues the precharge, and keeps ready low until the precharge period and the full row cycle time allow the next row open.

Every delay is given in nanoseconds and turned into a clock count by ceiling division by the clock-period parameter, with a floor of one cycle. All pin outputs come straight from flops.

Top module: `sdram_wr_seq`

## Requirements
- R1: During and directly after reset, and after a reset applied in the middle of a burst, the outputs are: `req_ready` = 1, command = NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `sd_dq_oe` = 0, `sd_dqm` all ones, `sd_addr` = 0 and `sd_ba` = 0.
- R2: When `req_valid` and `req_ready` are both high at a clock edge, the next cycle shows ACTIVE (4'b0011), with `sd_addr` = row and `sd_ba` = bank, and `req_ready` falls.
- R3: WRITE (4'b0100) appears exactly RCD cycles after ACTIVE, with NOP in between. During WRITE, `sd_addr[COL_W-1:0]` = column, `sd_addr[10]` = 0 (no automatic precharge), every other address bit = 0, and `sd_ba` = bank.
- R4: Data word k (`req_wdata[k*DQ_W +: DQ_W]`, k = 0..3) is driven on `sd_dq` in cycle WRITE+k, with `sd_dq_oe` = 1 and `sd_dqm` = 0. Outside these four cycles, `sd_dq` = 0, `sd_dq_oe` = 0 and `sd_dqm` is all ones.
- R5: PRECHARGE (4'b0010) appears at offset max(RCD+3+WR, RAS) after ACTIVE, and every cycle between the last data word and the precharge is NOP.
- R6: During PRECHARGE, `sd_addr[10]` equals the request's all-banks flag and every other address bit is 0. `sd_ba` is the bank for a single-bank precharge and 0 for an all-banks precharge.
- R7: `req_ready` rises in the cycle at offset NEXT-1 after ACTIVE, where NEXT = max(PRE+RP, RC). A request held valid back to back therefore puts its ACTIVE exactly NEXT cycles after the previous one, never sooner.
- R8: Each delay in cycles is the ceiling of its nanosecond value divided by `CLK_PERIOD_NS`, with a minimum of 1. At the defaults this gives RCD = 3, RAS = 6, RC = 8, WR = 2 and RP = 3.
- R9: While `req_ready` is low, `req_valid` and every request field are ignored. The burst in progress keeps the values captured at acceptance, and no ACTIVE is issued.
- R10: `sd_cke` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Burst start column |
| req_all_banks | input | 1 | 1: precharge all banks at the end; 0: precharge only the target bank |
| req_wdata | input | BL*DQ_W | Four burst words, word 0 in the low bits |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dq | output | DQ_W | Write data |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | DQ_W/8 | Byte masks, high = masked |

## Verification
The bench checks every cycle of each burst against a schedule it derives from the nanosecond parameters. A design that counted the write-recovery wait from the WRITE command instead of from the last data word would precharge two cycles early, and one that used floor division would come up a cycle short wherever a delay is not a whole number of clocks. Back-to-back requests test the row-cycle boundary. An early ready shows up as an ACTIVE arriving before the precharge period has run out. The bench also changes the request fields while a burst is running, which catches a design that keeps sampling its inputs after acceptance, and it checks that an all-ones column never sets the automatic-precharge bit. A reset issued after the WRITE must bring back NOP and release the data bus at once.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_WR,
        CMD_PRE
    } cmd_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } st_e;

    // nanoseconds to clocks, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_wr_cmdenc.sv
module sdram_wr_cmdenc
    import sdram_wr_pkg::*;
(
    input  cmd_e       cmd,
    output logic [3:0] pins   // {cs_n, ras_n, cas_n, we_n}
);
    always_comb begin
        unique case (cmd)
            CMD_ACT: pins = 4'b0011;
            CMD_WR:  pins = 4'b0100;
            CMD_PRE: pins = 4'b0010;
            default: pins = 4'b0111;
        endcase
    end
endmodule

// File: rtl/sdram_wr_sched.sv
module sdram_wr_sched
    import sdram_wr_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int BEAT_W = 2,
    parameter int BL     = 4,
    parameter int RCD_C  = 3,
    parameter int T_PRE  = 8
) (
    input  logic [CNT_W-1:0]  ofs,
    output cmd_e              cmd,
    output logic              burst,
    output logic [BEAT_W-1:0] beat
);
    localparam int T_LAST = RCD_C + BL - 1;

    always_comb begin
        if (ofs == '0)
            cmd = CMD_ACT;
        else if (ofs == CNT_W'(RCD_C))
            cmd = CMD_WR;
        else if (ofs == CNT_W'(T_PRE))
            cmd = CMD_PRE;
        else
            cmd = CMD_NOP;
    end

    assign burst = (ofs >= CNT_W'(RCD_C)) && (ofs <= CNT_W'(T_LAST));

    generate
        if (BL > 1) begin : g_multi
            logic [CNT_W-1:0] rel;
            assign rel  = ofs - CNT_W'(RCD_C);
            assign beat = rel[BEAT_W-1:0];
        end else begin : g_single
            assign beat = '0;
        end
    endgenerate
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RCD_NS      = 20,
    parameter int T_RAS_NS      = 42,
    parameter int T_RC_NS       = 60,
    parameter int T_WR_NS       = 15,
    parameter int T_RP_NS       = 20,
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 12,
    parameter int COL_W         = 9,
    parameter int DQ_W          = 16,
    parameter int BL            = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic                 req_all_banks,
    input  logic [BL*DQ_W-1:0]   req_wdata,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [ROW_W-1:0]     sd_addr,
    output logic [DQ_W-1:0]      sd_dq,
    output logic                 sd_dq_oe,
    output logic [DQ_W/8-1:0]    sd_dqm
);
    localparam int ADDR_W  = ROW_W;
    localparam int AP_BIT  = 10;
    localparam int DM_W    = DQ_W / 8;
    localparam int RCD_C   = ns_to_cyc(T_RCD_NS, CLK_PERIOD_NS);
    localparam int RAS_C   = ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS);
    localparam int RC_C    = ns_to_cyc(T_RC_NS,  CLK_PERIOD_NS);
    localparam int WR_C    = ns_to_cyc(T_WR_NS,  CLK_PERIOD_NS);
    localparam int RP_C    = ns_to_cyc(T_RP_NS,  CLK_PERIOD_NS);
    localparam int T_LAST  = RCD_C + BL - 1;
    localparam int T_PRE   = imax(T_LAST + WR_C, RAS_C);
    localparam int T_NEXT  = imax(T_PRE + RP_C, RC_C);
    localparam int CNT_W   = $clog2(T_NEXT + 1);
    localparam int BEAT_W  = (BL > 1) ? $clog2(BL) : 1;
    localparam logic [3:0] PINS_NOP = 4'b0111;

    typedef struct packed {
        st_e                 st;
        logic [CNT_W-1:0]    ofs;
        logic [BANK_W-1:0]   bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic                all;
        logic [BL*DQ_W-1:0]  wdata;
        logic                ready;
        logic                cke;
        logic [3:0]          pins;
        logic [BANK_W-1:0]   ba;
        logic [ADDR_W-1:0]   addr;
        logic [DQ_W-1:0]     dq;
        logic                oe;
        logic [DM_W-1:0]     dqm;
    } seq_t;

    seq_t q, d;

    logic              accept;
    logic              active_nx;
    logic [CNT_W-1:0]  ofs_nx;
    cmd_e              sched_cmd;
    cmd_e              cmd_sel;
    logic              burst;
    logic [BEAT_W-1:0] beat;
    logic [3:0]        enc_pins;

    // step of the burst schedule that the next cycle will show
    always_comb begin
        accept    = q.ready && req_valid;
        active_nx = accept || (q.st == ST_BUSY);
        if (accept)
            ofs_nx = '0;
        else if (q.st == ST_BUSY)
            ofs_nx = q.ofs + CNT_W'(1);
        else
            ofs_nx = q.ofs;
    end

    sdram_wr_sched #(
        .CNT_W  (CNT_W),
        .BEAT_W (BEAT_W),
        .BL     (BL),
        .RCD_C  (RCD_C),
        .T_PRE  (T_PRE)
    ) u_sched (
        .ofs   (ofs_nx),
        .cmd   (sched_cmd),
        .burst (burst),
        .beat  (beat)
    );

    assign cmd_sel = active_nx ? sched_cmd : CMD_NOP;

    sdram_wr_cmdenc u_enc (
        .cmd  (cmd_sel),
        .pins (enc_pins)
    );

    always_comb begin
        d     = q;
        d.ofs = ofs_nx;
        d.cke = 1'b1;

        if (accept) begin
            d.st    = ST_BUSY;
            d.ready = 1'b0;
            d.bank  = req_bank;
            d.row   = req_row;
            d.col   = req_col;
            d.all   = req_all_banks;
            d.wdata = req_wdata;
        end else if ((q.st == ST_BUSY) && (ofs_nx == CNT_W'(T_NEXT - 1))) begin
            d.st    = ST_IDLE;
            d.ready = 1'b1;
        end

        d.pins = enc_pins;
        d.addr = '0;
        d.ba   = '0;
        unique case (cmd_sel)
            CMD_ACT: begin
                d.addr = d.row;
                d.ba   = d.bank;
            end
            CMD_WR: begin
                d.addr[COL_W-1:0] = d.col;
                d.addr[AP_BIT]    = 1'b0;
                d.ba              = d.bank;
            end
            CMD_PRE: begin
                d.addr[AP_BIT] = d.all;
                d.ba           = d.all ? '0 : d.bank;
            end
            default: ;
        endcase

        if (active_nx && burst) begin
            d.dq  = d.wdata[beat*DQ_W +: DQ_W];
            d.oe  = 1'b1;
            d.dqm = '0;
        end else begin
            d.dq  = '0;
            d.oe  = 1'b0;
            d.dqm = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ready <= 1'b1;
            q.cke   <= 1'b1;
            q.pins  <= PINS_NOP;
            q.dqm   <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = q.ready;
    assign sd_cke    = q.cke;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = q.pins;
    assign sd_ba     = q.ba;
    assign sd_addr   = q.addr;
    assign sd_dq     = q.dq;
    assign sd_dq_oe  = q.oe;
    assign sd_dqm    = q.dqm;

endmodule

// File: rtl/sdram_wr_seq_chk.sv
module sdram_wr_seq_chk #(
    parameter int RCD_C  = 3,
    parameter int T_PRE  = 8,
    parameter int T_NEXT = 11,
    parameter int AP_BIT = 10,
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int DM_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              oe,
    input logic [DM_W-1:0]   dqm
);
    localparam int CW = $clog2(T_NEXT + 2);
    localparam logic [CW-1:0] SAT = '1;

    logic is_act, is_wr, is_pre;
    logic [CW-1:0] since_q;

    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_wr  = !cs_n &&  ras_n && !cas_n && !we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;

    // cycles since the last ACTIVE seen on the pins, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= SAT;
        else if (is_act)
            since_q <= CW'(1);
        else if (since_q != SAT)
            since_q <= since_q + CW'(1);
    end

    p_act_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> $past(req_valid && req_ready));
    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_wr_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> since_q == CW'(RCD_C));
    p_wr_no_autopre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> !addr[AP_BIT]);
    p_mask_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> dqm == '0);
    p_pre_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> since_q == CW'(T_PRE));
    p_pre_all_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && addr[AP_BIT]) |-> ba == '0);
    p_act_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> since_q >= CW'(T_NEXT));
    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !is_act);
    p_cke_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cke);

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
    .RCD_C  (RCD_C),
    .T_PRE  (T_PRE),
    .T_NEXT (T_NEXT),
    .AP_BIT (AP_BIT),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DM_W   (DM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cke       (sd_cke),
    .cs_n      (sd_cs_n),
    .ras_n     (sd_ras_n),
    .cas_n     (sd_cas_n),
    .we_n      (sd_we_n),
    .ba        (sd_ba),
    .addr      (sd_addr),
    .oe        (sd_dq_oe),
    .dqm       (sd_dqm)
);

// File: tb/sdram_wr_seq_tb.sv
`timescale 1ns/1ps
module sdram_wr_seq_tb;
    localparam int PER   = 8;
    localparam int RCD_NS = 20, RAS_NS = 42, RC_NS = 60, WR_NS = 15, RP_NS = 20;
    localparam int BANK_W = 2, ROW_W = 12, COL_W = 9, DQ_W = 16, BL = 4;

    function automatic int cyc(input int ns);
        int c;
        c = ns / PER;
        if (c * PER < ns) c = c + 1;
        if (c == 0) c = 1;
        return c;
    endfunction

    localparam int E_RCD  = cyc(RCD_NS);
    localparam int E_RAS  = cyc(RAS_NS);
    localparam int E_RC   = cyc(RC_NS);
    localparam int E_WR   = cyc(WR_NS);
    localparam int E_RP   = cyc(RP_NS);
    localparam int E_LAST = E_RCD + BL - 1;
    localparam int E_PRE  = (E_LAST + E_WR > E_RAS) ? E_LAST + E_WR : E_RAS;
    localparam int E_NEXT = (E_PRE + E_RP > E_RC) ? E_PRE + E_RP : E_RC;

    typedef struct packed {
        logic [1:0]  bank;
        logic [11:0] row;
        logic [8:0]  col;
        logic        all;
        logic        noise;
        logic [63:0] data;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd1, 12'hABC, 9'h1F3, 1'b0, 1'b0, 64'h1111_2222_3333_4444},
        '{2'd3, 12'h5A5, 9'h000, 1'b1, 1'b1, 64'hDEAD_BEEF_0F0F_F0F0},
        '{2'd0, 12'hFFF, 9'h1FF, 1'b0, 1'b0, 64'h0001_8000_7FFF_FFFF},
        '{2'd2, 12'h001, 9'h0AA, 1'b1, 1'b0, 64'hCAFE_0000_FFFF_1234}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_all = 0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [BL*DQ_W-1:0] req_wdata = '0;
    logic req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0]  sd_addr;
    logic [DQ_W-1:0]   sd_dq;
    logic [1:0]        sd_dqm;

    int n_tests = 0, n_fail = 0;

    always #(PER/2) clk = ~clk;

    sdram_wr_seq #(
        .CLK_PERIOD_NS(PER), .T_RCD_NS(RCD_NS), .T_RAS_NS(RAS_NS), .T_RC_NS(RC_NS),
        .T_WR_NS(WR_NS), .T_RP_NS(RP_NS), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .DQ_W(DQ_W), .BL(BL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_all_banks(req_all), .req_wdata(req_wdata), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe),
        .sd_dqm(sd_dqm)
    );

    // {cmd[3:0], ba, addr, dq, oe, dqm, ready, cke}
    localparam int OW = 4 + BANK_W + ROW_W + DQ_W + 1 + 2 + 1 + 1;

    function automatic logic [OW-1:0] observed();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, sd_dq,
                sd_dq_oe, sd_dqm, req_ready, sd_cke};
    endfunction

    localparam logic [OW-1:0] IDLE_EXP = {4'b0111, 2'b00, 12'h000, 16'h0000, 1'b0, 2'b11, 1'b1, 1'b1};

    function automatic logic [OW-1:0] expect_at(input vec_t v, input int k);
        logic [3:0] c;
        logic [1:0] b;
        logic [11:0] a;
        logic [15:0] dq;
        logic oe;
        c = 4'b0111; b = 2'b00; a = 12'h000; dq = 16'h0; oe = 1'b0;
        if (k == 0) begin c = 4'b0011; b = v.bank; a = v.row; end
        else if (k == E_RCD) begin c = 4'b0100; b = v.bank; a = {3'b000, v.col}; end
        else if (k == E_PRE) begin c = 4'b0010; b = v.all ? 2'b00 : v.bank; a = {1'b0, v.all, 10'h000}; end
        if (k >= E_RCD && k <= E_LAST) begin
            oe = 1'b1;
            dq = v.data[(k - E_RCD)*16 +: 16];
        end
        return {c, b, a, dq, oe, oe ? 2'b00 : 2'b11, (k == E_NEXT - 1), 1'b1};
    endfunction

    task automatic check(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input vec_t v);
        req_bank = v.bank; req_row = v.row; req_col = v.col;
        req_all = v.all; req_wdata = v.data; req_valid = 1'b1;
    endtask

    // called at a negedge with ready high; returns at negedge of offset NEXT-1
    task automatic run_burst(input vec_t v);
        string tag;
        drive_req(v);
        @(negedge clk);
        for (int k = 0; k < E_NEXT; k++) begin
            if (k == 0) tag = "R2 accept/ACTIVE";
            else if (k == E_RCD) tag = "R3 R8 WRITE timing/address";
            else if (k > E_RCD && k <= E_LAST) tag = "R4 burst data";
            else if (k == E_PRE) tag = "R5 R6 PRECHARGE time/scope";
            else if (k == E_NEXT - 1) tag = "R7 ready return";
            else if (k < E_RCD) tag = "R3 NOP before WRITE";
            else tag = "R5 NOP around PRECHARGE";
            if (v.noise && k > 0) tag = {tag, " R9 busy inputs ignored"};
            check(tag, observed(), expect_at(v, k));
            if (k == 0) begin
                if (v.noise) begin
                    req_bank = ~v.bank; req_row = ~v.row; req_col = ~v.col;
                    req_all = ~v.all; req_wdata = ~v.data;
                end else
                    req_valid = 1'b0;
            end
            if (v.noise && k == E_NEXT - 2) req_valid = 1'b0;
            if (k < E_NEXT - 1) @(negedge clk);
        end
    endtask

    initial begin
        #(PER * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 R10 outputs during reset", observed(), IDLE_EXP);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", observed(), IDLE_EXP);
        check("R8 derived cycle counts", {E_RCD[7:0], E_RAS[7:0], E_RC[7:0], E_WR[7:0], E_RP[7:0]} ,
              {8'd3, 8'd6, 8'd8, 8'd2, 8'd3});

        // table of vectors, issued back to back
        for (int i = 0; i < 4; i++) run_burst(VECS[i]);

        // idle: nothing requested, pins stay NOP
        req_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R7 R10 idle after last burst", observed(), IDLE_EXP);
        end

        // reset in the middle of a burst, just after WRITE
        drive_req(VECS[1]);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (E_RCD) @(negedge clk);
        check("R3 WRITE before mid-burst reset", observed(), expect_at(VECS[1], E_RCD));
        rst_n = 1'b0;
        #1;
        check("R1 mid-burst reset clears pins", observed(), IDLE_EXP);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after mid-burst reset", observed(), IDLE_EXP);
        run_burst(VECS[0]);
        req_valid = 1'b0;
        @(negedge clk);
        check("R7 idle after restart burst", observed(), IDLE_EXP);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule